// File: doc/BRIEF.md
# MDIO Management Frame Master

This block lets a controller read and write 16-bit PHY registers over a two-wire management link: a clock line (MDC) and a bidirectional data line (MDIO). A request is a one-cycle `start` strobe together with a direction bit, a 5-bit PHY address, a 5-bit register address and 16 bits of write data. The block latches the request and serialises a complete frame. When the frame ends it pulses `done` for one system clock. For a read, `rdata` carries the 16 bits taken from the PHY.

MDC is derived from the system clock. Each MDC half-period lasts `HALF_DIV` system clocks. The default of 25 keeps MDC at 2.5 MHz with a 125 MHz system clock. MDIO leaves the block as a data bit (`mdio_o`) and an output enable (`mdio_oe`), so the pad can be tri-stated. The pad's input value returns on `mdio_i`.

Every bit the master drives occupies one slot of three MDC half-periods: low, high, low. The bit is set up while MDC is low and held across the high phase. For a read, the master lets go of the line for one complete low-high-low slot. It then clocks in 16 bits, two half-periods each: high, then low. Each bit is sampled on the last system clock of the high half. For a write, the frame ends with a single released half-period with MDC low, and then `done` is raised.

Top module: `mdio_frame_master`

## Requirements
- R1: While reset is held, and afterwards until a request arrives, `mdc`, `mdio_oe` and `done` are all 0.
- R2: Every frame begins with 32 driven ones, followed by the start pattern 0 then 1.
- R3: After the start pattern the opcode is driven: 1,0 when `op_write`=0 (read) and 0,1 when `op_write`=1 (write).
- R4: The 5-bit PHY address is driven next, then the 5-bit register address, each most significant bit first.
- R5: Each driven bit spans exactly one MDC rising edge with `mdio_oe`=1. `mdio_o` and `mdio_oe` never change while MDC is high.
- R6: A write continues with the turnaround bits 1 then 0, then the 16 `wdata` bits MSB first, for 64 MDC rising edges in total.
- R7: A read releases MDIO (`mdio_oe`=0) for one full MDC low-high-low slot. It then samples 16 bits on `mdio_i` during the MDC high phases, MSB first. The frame has 63 MDC rising edges in total, and the sampled value appears on `rdata` when `done` pulses.
- R8: After the last write data bit, `mdio_oe` is 0 and MDC stays low for exactly `HALF_DIV` system clocks before `done` is raised.
- R9: `done` is a single-cycle pulse, with `mdc` and `mdio_oe` both 0 while it is high.
- R10: A `start` seen while a frame is in progress is ignored. The running frame keeps its latched fields, and no extra frame or `done` follows.
- R11: Every MDC high phase lasts exactly `HALF_DIV` system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request strobe, accepted only when idle |
| op_write | input | 1 | 1 = register write, 0 = register read |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wdata | input | 16 | Data for a write |
| rdata | output | 16 | Data from the last completed read |
| done | output | 1 | One-cycle pulse at the end of a frame |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data driven onto MDIO |
| mdio_oe | output | 1 | MDIO output enable (0 = released) |
| mdio_i | input | 1 | Value seen on the MDIO pad |

## Verification
The bench models a PHY that decodes every MDC rising edge and answers reads by changing `mdio_i` after each falling edge. A wrong turnaround length therefore shows up as a data value shifted by one bit. Sampling on the wrong MDC phase gives the same symptom, as does an off-by-one in the data field count.

The write tail is measured in system clocks between the release of MDIO and `done`. A block that skipped the released half-period, or raised `done` early, would show a short count.

Stray `start` strobes are sent in the middle of frames, and the request fields are scrambled after they are taken. A design that re-latched them would emit a corrupted or extra frame and a second `done`.

All-ones and all-zeros read data and single-bit write data are used to expose bit-order and edge errors.

// File: rtl/mdio_pkg.sv
// Shared frame constants and sequencer state type for the management master.
// Assumes the fixed 5-bit address / 16-bit data frame layout.
package mdio_pkg;
    localparam int PRE_BITS  = 32;
    localparam int ADDR_W    = 5;
    localparam int DATA_W    = 16;
    localparam int HDR_BITS  = PRE_BITS + 2 + 2 + ADDR_W + ADDR_W;   // driven part of any frame
    localparam int WR_BITS   = HDR_BITS + 2 + DATA_W;                // driven part of a write
    localparam int CNT_W     = $clog2(WR_BITS);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DRIVE,   // driven bit slots: low, high, low
        ST_TURN,    // read turnaround: released low, high, low
        ST_RECV,    // read data: high (sample), low
        ST_TAIL     // write tail: one released low half-period
    } seq_state_t;
endpackage

// File: rtl/mdc_phase_timer.sv
// Phase timer: while run is high, emits a one-cycle tick every HALF_DIV
// system clocks, marking the end of an MDC half-period.
// Assumes run rises on the cycle after a request is taken, so the first
// half-period is full length.
module mdc_phase_timer #(
    parameter int HALF_DIV = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == LAST);

    // Count system clocks within the current half-period; hold at zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end

    generate
        if (HALF_DIV > 1) begin : g_spacing
            // R11
            tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/mdio_frame_seq.sv
// Frame sequencer: latches one request, shifts the driven bits out of a
// preloaded register, handles the read turnaround and data sampling, and
// closes writes with a released low half-period.
// Assumes tick marks the end of each MDC half-period while run is high.
module mdio_frame_seq
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start,
    input  logic              op_write,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              mdio_i,
    output logic              run,
    output logic              mdc_o,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic [DATA_W-1:0] rdata,
    output logic              done
);
    seq_state_t          state;
    logic [1:0]          sub;
    logic [CNT_W-1:0]    bits_left;
    logic [WR_BITS-1:0]  shreg;
    logic                op_q;
    logic [DATA_W-1:0]   rx_sh;

    assign run     = (state != ST_IDLE);
    assign mdio_o  = shreg[WR_BITS-1];
    assign mdio_oe = (state == ST_DRIVE);
    // MDC is high in the middle phase of a three-phase slot, first phase of a receive slot.
    assign mdc_o   = ((state == ST_DRIVE || state == ST_TURN) && sub == 2'd1) ||
                     (state == ST_RECV && sub == 2'd0);

    // Step through frame fields, phases and read sampling on each half-period tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            sub       <= 2'd0;
            bits_left <= '0;
            shreg     <= '0;
            op_q      <= 1'b0;
            rx_sh     <= '0;
            rdata     <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: if (start) begin
                    state     <= ST_DRIVE;
                    sub       <= 2'd0;
                    op_q      <= op_write;
                    bits_left <= op_write ? CNT_W'(WR_BITS - 1) : CNT_W'(HDR_BITS - 1);
                    shreg     <= {{PRE_BITS{1'b1}}, 2'b01,
                                  (op_write ? 2'b01 : 2'b10),
                                  phy_addr, reg_addr, 2'b10, wdata};
                end
                ST_DRIVE: if (tick) begin
                    if (sub == 2'd2) begin
                        sub <= 2'd0;
                        if (bits_left == '0) begin
                            state <= op_q ? ST_TAIL : ST_TURN;
                        end else begin
                            bits_left <= bits_left - 1'b1;
                            shreg     <= {shreg[WR_BITS-2:0], 1'b0};
                        end
                    end else begin
                        sub <= sub + 2'd1;
                    end
                end
                ST_TURN: if (tick) begin
                    if (sub == 2'd2) begin
                        sub       <= 2'd0;
                        state     <= ST_RECV;
                        bits_left <= CNT_W'(DATA_W - 1);
                    end else begin
                        sub <= sub + 2'd1;
                    end
                end
                ST_RECV: if (tick) begin
                    if (sub == 2'd0) begin
                        rx_sh <= {rx_sh[DATA_W-2:0], mdio_i};
                        sub   <= 2'd1;
                    end else begin
                        sub <= 2'd0;
                        if (bits_left == '0) begin
                            state <= ST_IDLE;
                            rdata <= rx_sh;
                            done  <= 1'b1;
                        end else begin
                            bits_left <= bits_left - 1'b1;
                        end
                    end
                end
                ST_TAIL: if (tick) begin
                    state <= ST_IDLE;
                    done  <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R5
    mdio_stable_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc_o && $past(mdc_o)) |-> ($stable(mdio_o) && $stable(mdio_oe)));
    // R10
    op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> $stable(op_q));
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!mdc_o && !mdio_oe));
endmodule

// File: rtl/mdio_frame_master.sv
// Top of the management frame master: joins the half-period timer and the
// frame sequencer. Assumes mdio_i is the pad value, already stable around
// the end of each MDC high phase.
module mdio_frame_master #(
    parameter int HALF_DIV = 25
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        op_write,
    input  logic [4:0]  phy_addr,
    input  logic [4:0]  reg_addr,
    input  logic [15:0] wdata,
    output logic [15:0] rdata,
    output logic        done,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic run;
    logic tick;

    mdc_phase_timer #(.HALF_DIV(HALF_DIV)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    mdio_frame_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .start    (start),
        .op_write (op_write),
        .phy_addr (phy_addr),
        .reg_addr (reg_addr),
        .wdata    (wdata),
        .mdio_i   (mdio_i),
        .run      (run),
        .mdc_o    (mdc),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .rdata    (rdata),
        .done     (done)
    );
endmodule

// File: tb/mdio_frame_master_test.sv
// Scoreboard bench: the driver pushes expected frames, a PHY-side monitor
// decodes MDC edges, answers reads and compares each frame at done.
module mdio_frame_master_test;
    localparam int HD = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op_write = 1'b0;
    logic [4:0]  phy_addr = '0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        done, mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    always #4 clk = ~clk;   // 125 MHz

    mdio_frame_master #(.HALF_DIV(HD)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_write(op_write),
        .phy_addr(phy_addr), .reg_addr(reg_addr), .wdata(wdata),
        .rdata(rdata), .done(done), .mdc(mdc), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    typedef struct packed {
        logic        w;
        logic [4:0]  p;
        logic [4:0]  r;
        logic [15:0] d;
        logic [15:0] rv;
    } item_t;

    item_t exp_q[$];
    int total = 0;
    int fails = 0;
    int done_cnt = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // PHY-side monitor state
    logic bit_at [0:63];
    logic oe_at  [0:63];
    int   rise_n = 0;
    int   hi_cnt = 0;
    int   hi_bad = 0;
    int   quiet_cnt = 0;
    bit   moved_hi = 0;
    logic p_mdc = 0, p_mdo = 0, p_oe = 0, p_done = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            // frame evaluation at done, using counters from before this sample
            if (done) begin
                done_cnt++;
                chk(!p_done, "R9", "done width", {63'b0, p_done}, 64'h0);
                chk(!mdc && !mdio_oe, "R9", "lines quiet at done", {62'b0, mdc, mdio_oe}, 64'h0);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R10", "unexpected done", 64'h1, 64'h0);
                end else begin
                    item_t e;
                    logic [31:0] pre;
                    logic [1:0]  stv, opv, tav;
                    logic [4:0]  pv, rv;
                    logic [15:0] dv;
                    bit oe_ok;
                    e = exp_q.pop_front();
                    for (int i = 0; i < 32; i++) pre[31-i] = bit_at[i];
                    stv = {bit_at[32], bit_at[33]};
                    opv = {bit_at[34], bit_at[35]};
                    for (int i = 0; i < 5; i++) begin
                        pv[4-i] = bit_at[36+i];
                        rv[4-i] = bit_at[41+i];
                    end
                    chk(pre == 32'hFFFF_FFFF, "R2", "preamble", {32'b0, pre}, 64'hFFFF_FFFF);
                    chk(stv == 2'b01, "R2", "start field", {62'b0, stv}, 64'h1);
                    chk(opv == (e.w ? 2'b01 : 2'b10), "R3", "opcode", {62'b0, opv},
                        e.w ? 64'h1 : 64'h2);
                    chk(pv == e.p, "R4", "phy address", {59'b0, pv}, {59'b0, e.p});
                    chk(rv == e.r, "R4", "register address", {59'b0, rv}, {59'b0, e.r});
                    oe_ok = 1;
                    for (int i = 0; i < (e.w ? 64 : 46); i++) if (oe_at[i] !== 1'b1) oe_ok = 0;
                    chk(oe_ok, "R5", "driven bits enabled", {63'b0, oe_ok}, 64'h1);
                    chk(!moved_hi, "R5", "change while MDC high", {63'b0, moved_hi}, 64'h0);
                    chk(hi_bad == 0, "R11", "high phase widths", hi_bad, 64'h0);
                    if (e.w) begin
                        tav = {bit_at[46], bit_at[47]};
                        for (int i = 0; i < 16; i++) dv[15-i] = bit_at[48+i];
                        chk(rise_n == 64, "R6", "write rising edges", rise_n, 64);
                        chk(tav == 2'b10, "R6", "write turnaround", {62'b0, tav}, 64'h2);
                        chk(dv == e.d, "R6", "write data", {48'b0, dv}, {48'b0, e.d});
                        chk(quiet_cnt == HD, "R8", "released tail clocks", quiet_cnt, HD);
                    end else begin
                        oe_ok = 1;
                        for (int i = 46; i < 63; i++) if (oe_at[i] !== 1'b0) oe_ok = 0;
                        chk(rise_n == 63, "R7", "read rising edges", rise_n, 63);
                        chk(oe_ok, "R7", "released during turnaround and data", {63'b0, oe_ok}, 64'h1);
                        chk(rdata == e.rv, "R7", "read data", {48'b0, rdata}, {48'b0, e.rv});
                    end
                end
                rise_n = 0; hi_bad = 0; hi_cnt = 0; moved_hi = 0; mdio_i = 1'b1;
            end
            // edge decoding
            if (mdc && !p_mdc && rise_n < 64) begin
                bit_at[rise_n] = mdio_o;
                oe_at[rise_n]  = mdio_oe;
                rise_n++;
            end
            if (mdc && p_mdc && (mdio_o != p_mdo || mdio_oe != p_oe)) moved_hi = 1;
            if (mdc) hi_cnt++;
            if (!mdc && p_mdc) begin
                if (hi_cnt != HD) hi_bad++;
                hi_cnt = 0;
                // PHY answer: next read bit after each fall from the turnaround on
                if (exp_q.size() != 0 && !exp_q[0].w && rise_n >= 47 && rise_n < 63)
                    mdio_i = exp_q[0].rv[15-(rise_n-47)];
            end
            if (mdio_oe || mdc) quiet_cnt = 0;
            else                quiet_cnt++;
        end
        p_mdc = mdc; p_mdo = mdio_o; p_oe = mdio_oe; p_done = done;
    end

    // Driver: issue one request, optionally poke start mid-frame, wait for done.
    task automatic run_frame(input logic w, input logic [4:0] p, input logic [4:0] r,
                             input logic [15:0] d, input logic [15:0] rv, input bit poke);
        int target;
        item_t it;
        it.w = w; it.p = p; it.r = r; it.d = d; it.rv = rv;
        target = done_cnt + 1;
        @(negedge clk);
        exp_q.push_back(it);
        start = 1'b1; op_write = w; phy_addr = p; reg_addr = r; wdata = d;
        @(negedge clk);
        start = 1'b0; op_write = ~w; phy_addr = ~p; reg_addr = ~r; wdata = ~d;
        if (poke) begin
            // R10: stray request during the frame
            repeat (60) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (200) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (done_cnt < target) @(negedge clk);
        repeat (40) @(negedge clk);
        chk(done_cnt == target, "R10", "done count after frame", done_cnt, target);
        chk(!mdc && !mdio_oe, "R1", "idle lines between frames", {62'b0, mdc, mdio_oe}, 64'h0);
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            total++; fails++;
            $display("FAIL watchdog: actual %0d expected done", cyc);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!mdc && !mdio_oe && !done, "R1", "outputs in reset",
            {61'b0, mdc, mdio_oe, done}, 64'h0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        chk(!mdc && !mdio_oe && !done, "R1", "outputs idle after reset",
            {61'b0, mdc, mdio_oe, done}, 64'h0);

        run_frame(1'b1, 5'h1F, 5'h00, 16'h8000, 16'h0000, 0);
        run_frame(1'b0, 5'h01, 5'h1F, 16'h0000, 16'hA5C3, 0);
        run_frame(1'b1, 5'h15, 5'h0A, 16'h0001, 16'h0000, 1);
        run_frame(1'b0, 5'h0A, 5'h15, 16'h1234, 16'hFFFF, 1);
        run_frame(1'b0, 5'h00, 5'h01, 16'hFFFF, 16'h0000, 0);
        run_frame(1'b1, 5'h10, 5'h11, 16'hFFFF, 16'h0000, 0);
        run_frame(1'b0, 5'h1E, 5'h02, 16'h0000, 16'h8001, 0);

        chk(exp_q.size() == 0, "R10", "scoreboard drained", exp_q.size(), 64'h0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule